// File: doc/BRIEF.md
# Call-Bracketing Broadcast Handshake Unit

This unit sits beside one producer core and fences a system call or an instrumented library call that is not itself logged. When the core reaches the call, the unit broadcasts a leave message to every other core. When the call returns, it broadcasts a return message. Each message carries the sender's current record counter and the address range the call may touch. The unit then stalls the core until every other core has acknowledged. It then writes one log record per acknowledging core, in ascending core order, and each record holds that core's counter. The lifeguard side later reads the leave records as arcs from the receivers to the sender and the return records as arcs from the sender to the receivers. Only the record type codes matter for that.

The same unit also handles the receiving side for its own core. Every incoming message goes into a small parking queue. While the local thread is scheduled, the head of the queue waits until the local pending-entry buffer is empty. The message is then logged with all of its fields and acknowledged with the local counter. While the thread is descheduled, a message is acknowledged at once so that the sender is not held up. Its log record is written later, in arrival order, once the thread runs again. The interconnect is modelled as plain per-core message and acknowledgement ports.

Top module: `call_fence_node`

## Requirements
- R1: After reset, busy_o, bc_valid_o, log_valid_o, ack_valid_o and drain_req_o are all 0.
- R2: A call request is accepted on a clock edge where call_req_i is 1 and busy_o is 0. The edge after acceptance produces exactly one one-cycle broadcast with bc_kind_o (0 = leave, 1 = return) taken from call_kind_i, bc_src_o equal to CORE_ID, bc_cnt_o equal to local_cnt_i, and the call range on bc_lo_o/bc_hi_o. busy_o rises on that same edge.
- R3: busy_o stays 1 and no further request is accepted until an acknowledgement has arrived from every other core. The unit then logs one record per other core in ascending core id, with type 3 for leave or 4 for return. log_core_o is the acknowledging core, log_cnt_o is the counter that core acknowledged with, and log_lo_o/log_hi_o hold the call range. busy_o falls after the last of these records.
- R4: An acknowledgement is ignored when no broadcast is outstanding, when it comes from CORE_ID, or when it repeats a core already acknowledged. In the repeat case the first counter is kept.
- R5: A received message is logged when the thread is scheduled and the pending buffer is empty. The record has type 1 for leave or 2 for return and carries the sender id, the sender counter, and the range. One acknowledgement is then sent to the sender, carrying local_cnt_i.
- R6: While pend_empty_i is 0, a waiting received message is neither logged nor acknowledged, and drain_req_o is 1. It proceeds once the buffer is empty.
- R7: A message received while thr_sched_i is 0 is acknowledged immediately with local_cnt_i and is not logged. After rescheduling, parked messages are logged in arrival order and are not acknowledged a second time.
- R8: A received message whose source is CORE_ID is ignored: no record and no acknowledgement.
- R9: When a received record and a sender acknowledgement record are ready in the same cycle, the received record takes the log port first. The other record is delayed, not lost.
- R10: The parking queue never takes a message while it is full. The environment keeps outstanding messages within PARK_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req_i | input | 1 | Call boundary reached; held until accepted |
| call_kind_i | input | 1 | 0 = leaving normal processing, 1 = returning |
| call_lo_i | input | AW | Lowest address the call may touch |
| call_hi_i | input | AW | Highest address the call may touch |
| local_cnt_i | input | CW | Local record counter |
| busy_o | output | 1 | Broadcast outstanding; core stalls |
| bc_valid_o | output | 1 | Broadcast message valid |
| bc_kind_o | output | 1 | Broadcast kind |
| bc_src_o | output | IDW | Broadcasting core id |
| bc_cnt_o | output | CW | Sender counter |
| bc_lo_o | output | AW | Range low |
| bc_hi_o | output | AW | Range high |
| rx_valid_i | input | 1 | Incoming message valid |
| rx_kind_i | input | 1 | Incoming kind |
| rx_src_i | input | IDW | Incoming sender id |
| rx_cnt_i | input | CW | Incoming sender counter |
| rx_lo_i | input | AW | Incoming range low |
| rx_hi_i | input | AW | Incoming range high |
| thr_sched_i | input | 1 | Local monitored thread is scheduled |
| pend_empty_i | input | 1 | Local pending log entries all enqueued |
| drain_req_o | output | 1 | Request to drain pending entries |
| ack_valid_o | output | 1 | Outgoing acknowledgement valid |
| ack_dst_o | output | IDW | Core being acknowledged |
| ack_cnt_o | output | CW | Local counter carried by the acknowledgement |
| ack_valid_i | input | 1 | Incoming acknowledgement valid |
| ack_src_i | input | IDW | Acknowledging core |
| ack_cnt_i | input | CW | Acknowledging core's counter |
| log_valid_o | output | 1 | Log record valid |
| log_type_o | output | 3 | 1/2 received leave/return, 3/4 collected ack leave/return |
| log_core_o | output | IDW | Other core named by the record |
| log_cnt_o | output | CW | Counter in the record |
| log_lo_o | output | AW | Range low |
| log_hi_o | output | AW | Range high |

## Verification
The bench sends acknowledgements out of order, sends a repeated acknowledgement with a different counter, sends one from the unit's own id, and sends a stray one while idle. A design that counted acknowledgements instead of tracking which cores had answered would finish early, log the wrong counter, or let a stale acknowledgement satisfy a later broadcast. It holds a second call request high during collection, which catches a unit that starts a new broadcast before the first completes. It toggles scheduling and the pending-buffer state around arriving messages, which catches acknowledgements sent twice or before draining, and parked records logged out of order. It also lines up a received record with the first collected-acknowledgement record in the same cycle, which exposes a wrong port priority as a reordered log.

// File: rtl/callfence_pkg.sv
package callfence_pkg;
  typedef enum logic [2:0] {
    REC_NONE    = 3'd0,
    REC_RX_OFF  = 3'd1,
    REC_RX_ON   = 3'd2,
    REC_ACK_OFF = 3'd3,
    REC_ACK_ON  = 3'd4
  } rec_e;

  localparam logic KIND_OFF = 1'b0;
  localparam logic KIND_ON  = 1'b1;
endpackage

// File: rtl/cfn_park_fifo.sv
module cfn_park_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && !full_o) wr_q <= bump(wr_q);
      if (pop_i && !empty_o) rd_q <= bump(rd_q);
      case ({push_i && !full_o, pop_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (32'(cnt_q) == DEPTH);

  // R10: the parking queue is never offered a message while full
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    !(push_i && full_o));
endmodule

// File: rtl/cfn_sender.sv
module cfn_sender
  import callfence_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int CORE_ID = 1,
  parameter int CW      = 16,
  parameter int AW      = 16,
  parameter int IDW     = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_req_i,
  input  logic           call_kind_i,
  input  logic [AW-1:0]  call_lo_i,
  input  logic [AW-1:0]  call_hi_i,
  input  logic [CW-1:0]  local_cnt_i,
  input  logic           ack_valid_i,
  input  logic [IDW-1:0] ack_src_i,
  input  logic [CW-1:0]  ack_cnt_i,
  input  logic           log_gnt_i,
  output logic           busy_o,
  output logic           bc_valid_o,
  output logic           bc_kind_o,
  output logic [IDW-1:0] bc_src_o,
  output logic [CW-1:0]  bc_cnt_o,
  output logic [AW-1:0]  bc_lo_o,
  output logic [AW-1:0]  bc_hi_o,
  output logic           tx_want_o,
  output logic [2:0]     tx_type_o,
  output logic [IDW-1:0] tx_core_o,
  output logic [CW-1:0]  tx_cnt_o,
  output logic [AW-1:0]  tx_lo_o,
  output logic [AW-1:0]  tx_hi_o
);
  localparam logic [NCORES-1:0] ONE    = NCORES'(1);
  localparam logic [NCORES-1:0] OTHERS = {NCORES{1'b1}} ^ (ONE << CORE_ID);
  localparam logic [IDW-1:0]    SELF   = IDW'(CORE_ID);
  localparam logic [IDW-1:0]    LAST   = IDW'(NCORES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DUMP} st_e;

  st_e             state_q;
  logic [NCORES-1:0] seen_q;
  logic [IDW-1:0]  idx_q;
  logic            kind_q;
  logic [AW-1:0]   lo_q, hi_q;
  logic [CW-1:0]   ack_mem [NCORES];
  logic            accept, ack_take, advance;

  assign accept   = call_req_i && (state_q == S_IDLE);
  assign ack_take = ack_valid_i && (state_q == S_WAIT) && (ack_src_i != SELF)
                    && (32'(ack_src_i) < NCORES) && !seen_q[ack_src_i];
  assign advance  = (state_q == S_DUMP) && ((idx_q == SELF) || log_gnt_i);

  always_ff @(posedge clk) begin
    if (ack_take) ack_mem[ack_src_i] <= ack_cnt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      seen_q     <= '0;
      idx_q      <= '0;
      kind_q     <= KIND_OFF;
      lo_q       <= '0;
      hi_q       <= '0;
      bc_valid_o <= 1'b0;
      bc_kind_o  <= KIND_OFF;
      bc_cnt_o   <= '0;
      bc_lo_o    <= '0;
      bc_hi_o    <= '0;
    end else begin
      bc_valid_o <= accept;
      case (state_q)
        S_IDLE: if (accept) begin
          state_q   <= S_WAIT;
          seen_q    <= '0;
          kind_q    <= call_kind_i;
          lo_q      <= call_lo_i;
          hi_q      <= call_hi_i;
          bc_kind_o <= call_kind_i;
          bc_cnt_o  <= local_cnt_i;
          bc_lo_o   <= call_lo_i;
          bc_hi_o   <= call_hi_i;
        end
        S_WAIT: begin
          if (ack_take) seen_q[ack_src_i] <= 1'b1;
          if (seen_q == OTHERS) begin
            state_q <= S_DUMP;
            idx_q   <= '0;
          end
        end
        S_DUMP: if (advance) begin
          if (idx_q == LAST) state_q <= S_IDLE;
          else               idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign bc_src_o  = SELF;
  assign tx_want_o = (state_q == S_DUMP) && (idx_q != SELF);
  assign tx_type_o = kind_q ? REC_ACK_ON : REC_ACK_OFF;
  assign tx_core_o = idx_q;
  assign tx_cnt_o  = ack_mem[idx_q];
  assign tx_lo_o   = lo_q;
  assign tx_hi_o   = hi_q;

  // R2: a broadcast is a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    bc_valid_o |=> !bc_valid_o);
  // R3: a request offered while busy does not start a broadcast
  p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && call_req_i) |=> !bc_valid_o);
  // R3: collected records are written only once every other core answered
  p_dump_after_all_r3: assert property (@(posedge clk) disable iff (rst)
    tx_want_o |-> (seen_q == OTHERS));
endmodule

// File: rtl/cfn_receiver.sv
module cfn_receiver
  import callfence_pkg::*;
#(
  parameter int CORE_ID    = 1,
  parameter int CW         = 16,
  parameter int AW         = 16,
  parameter int IDW        = 2,
  parameter int PARK_DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_valid_i,
  input  logic           rx_kind_i,
  input  logic [IDW-1:0] rx_src_i,
  input  logic [CW-1:0]  rx_cnt_i,
  input  logic [AW-1:0]  rx_lo_i,
  input  logic [AW-1:0]  rx_hi_i,
  input  logic           thr_sched_i,
  input  logic           pend_empty_i,
  input  logic [CW-1:0]  local_cnt_i,
  output logic           rec_fire_o,
  output logic [2:0]     rec_type_o,
  output logic [IDW-1:0] rec_core_o,
  output logic [CW-1:0]  rec_cnt_o,
  output logic [AW-1:0]  rec_lo_o,
  output logic [AW-1:0]  rec_hi_o,
  output logic           ack_fire_o,
  output logic [IDW-1:0] ack_dst_o,
  output logic [CW-1:0]  ack_cnt_o,
  output logic           drain_o
);
  localparam int DW = 2 + IDW + CW + 2 * AW;
  localparam logic [IDW-1:0] SELF = IDW'(CORE_ID);

  typedef struct packed {
    logic           acked;
    logic           kind;
    logic [IDW-1:0] src;
    logic [CW-1:0]  cnt;
    logic [AW-1:0]  lo;
    logic [AW-1:0]  hi;
  } park_t;

  park_t   wr_e, hd_e;
  logic    push, pop, empty, full;
  logic [DW-1:0] hd_raw;

  assign push = rx_valid_i && (rx_src_i != SELF);
  assign pop  = !empty && thr_sched_i && pend_empty_i;

  always_comb begin
    wr_e.acked = !thr_sched_i;
    wr_e.kind  = rx_kind_i;
    wr_e.src   = rx_src_i;
    wr_e.cnt   = rx_cnt_i;
    wr_e.lo    = rx_lo_i;
    wr_e.hi    = rx_hi_i;
  end

  cfn_park_fifo #(.DW(DW), .DEPTH(PARK_DEPTH)) park_i (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .wdata_i (wr_e),
    .pop_i   (pop),
    .rdata_o (hd_raw),
    .empty_o (empty),
    .full_o  (full)
  );

  assign hd_e = park_t'(hd_raw);

  assign rec_fire_o = pop;
  assign rec_type_o = hd_e.kind ? REC_RX_ON : REC_RX_OFF;
  assign rec_core_o = hd_e.src;
  assign rec_cnt_o  = hd_e.cnt;
  assign rec_lo_o   = hd_e.lo;
  assign rec_hi_o   = hd_e.hi;

  // parked arrivals are answered at once; scheduled ones after logging
  assign ack_fire_o = (push && !thr_sched_i) || (pop && !hd_e.acked);
  assign ack_dst_o  = (push && !thr_sched_i) ? rx_src_i : hd_e.src;
  assign ack_cnt_o  = local_cnt_i;
  assign drain_o    = thr_sched_i && !empty && !pend_empty_i;
endmodule

// File: rtl/call_fence_node.sv
module call_fence_node
  import callfence_pkg::*;
#(
  parameter int NCORES     = 4,
  parameter int CORE_ID    = 1,
  parameter int CW         = 16,
  parameter int AW         = 16,
  parameter int PARK_DEPTH = 8,
  localparam int IDW       = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_req_i,
  input  logic           call_kind_i,
  input  logic [AW-1:0]  call_lo_i,
  input  logic [AW-1:0]  call_hi_i,
  input  logic [CW-1:0]  local_cnt_i,
  output logic           busy_o,
  output logic           bc_valid_o,
  output logic           bc_kind_o,
  output logic [IDW-1:0] bc_src_o,
  output logic [CW-1:0]  bc_cnt_o,
  output logic [AW-1:0]  bc_lo_o,
  output logic [AW-1:0]  bc_hi_o,
  input  logic           rx_valid_i,
  input  logic           rx_kind_i,
  input  logic [IDW-1:0] rx_src_i,
  input  logic [CW-1:0]  rx_cnt_i,
  input  logic [AW-1:0]  rx_lo_i,
  input  logic [AW-1:0]  rx_hi_i,
  input  logic           thr_sched_i,
  input  logic           pend_empty_i,
  output logic           drain_req_o,
  output logic           ack_valid_o,
  output logic [IDW-1:0] ack_dst_o,
  output logic [CW-1:0]  ack_cnt_o,
  input  logic           ack_valid_i,
  input  logic [IDW-1:0] ack_src_i,
  input  logic [CW-1:0]  ack_cnt_i,
  output logic           log_valid_o,
  output logic [2:0]     log_type_o,
  output logic [IDW-1:0] log_core_o,
  output logic [CW-1:0]  log_cnt_o,
  output logic [AW-1:0]  log_lo_o,
  output logic [AW-1:0]  log_hi_o
);
  logic           tx_want, rx_fire, ack_fire, drain;
  logic [2:0]     tx_type, rx_type;
  logic [IDW-1:0] tx_core, rx_core, ack_dst;
  logic [CW-1:0]  tx_cnt, rx_cnt, ack_cnt;
  logic [AW-1:0]  tx_lo, tx_hi, rx_lo, rx_hi;

  cfn_sender #(.NCORES(NCORES), .CORE_ID(CORE_ID), .CW(CW), .AW(AW), .IDW(IDW)) snd_i (
    .clk (clk), .rst (rst),
    .call_req_i (call_req_i), .call_kind_i (call_kind_i),
    .call_lo_i (call_lo_i), .call_hi_i (call_hi_i), .local_cnt_i (local_cnt_i),
    .ack_valid_i (ack_valid_i), .ack_src_i (ack_src_i), .ack_cnt_i (ack_cnt_i),
    .log_gnt_i (!rx_fire), .busy_o (busy_o),
    .bc_valid_o (bc_valid_o), .bc_kind_o (bc_kind_o), .bc_src_o (bc_src_o),
    .bc_cnt_o (bc_cnt_o), .bc_lo_o (bc_lo_o), .bc_hi_o (bc_hi_o),
    .tx_want_o (tx_want), .tx_type_o (tx_type), .tx_core_o (tx_core),
    .tx_cnt_o (tx_cnt), .tx_lo_o (tx_lo), .tx_hi_o (tx_hi)
  );

  cfn_receiver #(.CORE_ID(CORE_ID), .CW(CW), .AW(AW), .IDW(IDW),
                 .PARK_DEPTH(PARK_DEPTH)) rcv_i (
    .clk (clk), .rst (rst),
    .rx_valid_i (rx_valid_i), .rx_kind_i (rx_kind_i), .rx_src_i (rx_src_i),
    .rx_cnt_i (rx_cnt_i), .rx_lo_i (rx_lo_i), .rx_hi_i (rx_hi_i),
    .thr_sched_i (thr_sched_i), .pend_empty_i (pend_empty_i),
    .local_cnt_i (local_cnt_i),
    .rec_fire_o (rx_fire), .rec_type_o (rx_type), .rec_core_o (rx_core),
    .rec_cnt_o (rx_cnt), .rec_lo_o (rx_lo), .rec_hi_o (rx_hi),
    .ack_fire_o (ack_fire), .ack_dst_o (ack_dst), .ack_cnt_o (ack_cnt),
    .drain_o (drain)
  );

  // shared log port: received records first (R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      log_valid_o <= 1'b0;
      log_type_o  <= REC_NONE;
      log_core_o  <= '0;
      log_cnt_o   <= '0;
      log_lo_o    <= '0;
      log_hi_o    <= '0;
      ack_valid_o <= 1'b0;
      ack_dst_o   <= '0;
      ack_cnt_o   <= '0;
      drain_req_o <= 1'b0;
    end else begin
      log_valid_o <= rx_fire || tx_want;
      if (rx_fire) begin
        log_type_o <= rx_type;
        log_core_o <= rx_core;
        log_cnt_o  <= rx_cnt;
        log_lo_o   <= rx_lo;
        log_hi_o   <= rx_hi;
      end else if (tx_want) begin
        log_type_o <= tx_type;
        log_core_o <= tx_core;
        log_cnt_o  <= tx_cnt;
        log_lo_o   <= tx_lo;
        log_hi_o   <= tx_hi;
      end
      ack_valid_o <= ack_fire;
      ack_dst_o   <= ack_dst;
      ack_cnt_o   <= ack_cnt;
      drain_req_o <= drain;
    end
  end

  // R6: a received record only follows a cycle with the thread running and no pending entries
  p_rx_log_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (log_valid_o && (log_type_o == REC_RX_OFF || log_type_o == REC_RX_ON))
      |-> ($past(thr_sched_i) && $past(pend_empty_i)));
  // R8: the unit never acknowledges itself
  p_no_self_ack_r8: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> (ack_dst_o != IDW'(CORE_ID)));
  // R1: outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!log_valid_o && !ack_valid_o && !bc_valid_o));
endmodule

// File: tb/call_fence_node_tb_top.sv
`timescale 1ns/1ps
module call_fence_node_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        call_req, call_kind, rx_valid, rx_kind, sched, pend_empty, ack_in_v;
  logic [15:0] call_lo, call_hi, lcnt, rx_cnt, rx_lo, rx_hi, ack_in_cnt;
  logic [1:0]  rx_src, ack_in_src;
  logic        busy, bc_valid, bc_kind, drain_req, ack_valid, log_valid;
  logic [1:0]  bc_src, ack_dst, log_core;
  logic [15:0] bc_cnt, bc_lo, bc_hi, ack_cnt, log_cnt, log_lo, log_hi;
  logic [2:0]  log_type;

  call_fence_node dut_i (
    .clk (clk), .rst (rst),
    .call_req_i (call_req), .call_kind_i (call_kind), .call_lo_i (call_lo),
    .call_hi_i (call_hi), .local_cnt_i (lcnt), .busy_o (busy),
    .bc_valid_o (bc_valid), .bc_kind_o (bc_kind), .bc_src_o (bc_src),
    .bc_cnt_o (bc_cnt), .bc_lo_o (bc_lo), .bc_hi_o (bc_hi),
    .rx_valid_i (rx_valid), .rx_kind_i (rx_kind), .rx_src_i (rx_src),
    .rx_cnt_i (rx_cnt), .rx_lo_i (rx_lo), .rx_hi_i (rx_hi),
    .thr_sched_i (sched), .pend_empty_i (pend_empty), .drain_req_o (drain_req),
    .ack_valid_o (ack_valid), .ack_dst_o (ack_dst), .ack_cnt_o (ack_cnt),
    .ack_valid_i (ack_in_v), .ack_src_i (ack_in_src), .ack_cnt_i (ack_in_cnt),
    .log_valid_o (log_valid), .log_type_o (log_type), .log_core_o (log_core),
    .log_cnt_o (log_cnt), .log_lo_o (log_lo), .log_hi_o (log_hi)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [52:0] logq[$];
  logic [17:0] ackq[$];
  logic [50:0] bcq[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (log_valid) logq.push_back({log_type, log_core, log_cnt, log_lo, log_hi});
      if (ack_valid) ackq.push_back({ack_dst, ack_cnt});
      if (bc_valid)  bcq.push_back({bc_kind, bc_src, bc_cnt, bc_lo, bc_hi});
    end
  end

  function automatic logic [52:0] rec(input logic [2:0] t, input logic [1:0] c,
                                      input logic [15:0] n, input logic [15:0] lo,
                                      input logic [15:0] hi);
    return {t, c, n, lo, hi};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_ack(input logic [1:0] s, input logic [15:0] c);
    ack_in_v = 1; ack_in_src = s; ack_in_cnt = c;
    tick(1);
    ack_in_v = 0;
  endtask

  task automatic send_msg(input logic k, input logic [1:0] s, input logic [15:0] c,
                          input logic [15:0] lo, input logic [15:0] hi);
    rx_valid = 1; rx_kind = k; rx_src = s; rx_cnt = c; rx_lo = lo; rx_hi = hi;
    tick(1);
    rx_valid = 0;
  endtask

  task automatic start_call(input logic k, input logic [15:0] lo, input logic [15:0] hi);
    call_req = 1; call_kind = k; call_lo = lo; call_hi = hi;
    tick(1);
    call_req = 0;
  endtask

  task automatic clear_q();
    logq.delete(); ackq.delete(); bcq.delete();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [52:0] exp_log[$];
    int          per_src[4];
    int          got_src[4];
    void'($urandom(32'd4242));
    call_req = 0; call_kind = 0; call_lo = 0; call_hi = 0; lcnt = 16'h0123;
    rx_valid = 0; rx_kind = 0; rx_src = 0; rx_cnt = 0; rx_lo = 0; rx_hi = 0;
    sched = 1; pend_empty = 1; ack_in_v = 0; ack_in_src = 0; ack_in_cnt = 0;
    tick(3);
    rst = 0;
    tick(1);
    // R1
    chk({busy, bc_valid, log_valid, ack_valid, drain_req} == 5'b0, "R1 reset outputs",
        {busy, bc_valid, log_valid, ack_valid, drain_req}, 0);

    // R2: leave broadcast
    clear_q();
    start_call(1'b0, 16'h1000, 16'h10ff);
    tick(1);
    chk(bcq.size() == 1, "R2 one broadcast", bcq.size(), 1);
    if (bcq.size() > 0)
      chk(bcq[0] == {1'b0, 2'd1, 16'h0123, 16'h1000, 16'h10ff}, "R2 broadcast fields",
          bcq[0], {1'b0, 2'd1, 16'h0123, 16'h1000, 16'h10ff});
    chk(busy == 1, "R2 busy raised", busy, 1);

    // R3: second request held while collecting, acks out of order
    call_req = 1; call_kind = 1; call_lo = 16'h2000; call_hi = 16'h2040;
    send_ack(2'd3, 16'h0033);
    send_ack(2'd0, 16'h0010);
    tick(5);
    chk(busy == 1, "R3 busy until all acks", busy, 1);
    chk(bcq.size() == 1, "R3 no second broadcast while busy", bcq.size(), 1);
    chk(logq.size() == 0, "R3 nothing logged before all acks", logq.size(), 0);
    // R4: own id and duplicate ignored
    send_ack(2'd1, 16'h0011);
    send_ack(2'd3, 16'h0ddd);
    tick(4);
    chk(logq.size() == 0, "R4 own/duplicate ack not counted", logq.size(), 0);
    send_ack(2'd2, 16'h0022);
    tick(8);
    chk(logq.size() == 3, "R3 three ack records", logq.size(), 3);
    if (logq.size() == 3) begin
      chk(logq[0] == rec(3'd3, 2'd0, 16'h0010, 16'h1000, 16'h10ff), "R3 record core0",
          logq[0], rec(3'd3, 2'd0, 16'h0010, 16'h1000, 16'h10ff));
      chk(logq[1] == rec(3'd3, 2'd2, 16'h0022, 16'h1000, 16'h10ff), "R3 record core2",
          logq[1], rec(3'd3, 2'd2, 16'h0022, 16'h1000, 16'h10ff));
      chk(logq[2] == rec(3'd3, 2'd3, 16'h0033, 16'h1000, 16'h10ff), "R4 first counter kept",
          logq[2], rec(3'd3, 2'd3, 16'h0033, 16'h1000, 16'h10ff));
    end
    call_req = 0;
    chk(bcq.size() == 2, "R3 held request accepted after completion", bcq.size(), 2);
    if (bcq.size() == 2)
      chk(bcq[1] == {1'b1, 2'd1, 16'h0123, 16'h2000, 16'h2040}, "R2 return broadcast",
          bcq[1], {1'b1, 2'd1, 16'h0123, 16'h2000, 16'h2040});

    // R3: return collection
    logq.delete();
    send_ack(2'd2, 16'h0a02);
    send_ack(2'd0, 16'h0a00);
    send_ack(2'd3, 16'h0a03);
    tick(8);
    chk(busy == 0, "R3 busy falls", busy, 0);
    chk(logq.size() == 3 && logq[0] == rec(3'd4, 2'd0, 16'h0a00, 16'h2000, 16'h2040),
        "R3 return record first", logq.size() > 0 ? logq[0] : 0,
        rec(3'd4, 2'd0, 16'h0a00, 16'h2000, 16'h2040));

    // R4: stray ack while idle does not count later
    clear_q();
    send_ack(2'd0, 16'h0bad);
    tick(2);
    start_call(1'b0, 16'h3000, 16'h3001);
    send_ack(2'd2, 16'h0b02);
    send_ack(2'd3, 16'h0b03);
    tick(6);
    chk(busy == 1 && logq.size() == 0, "R4 idle ack ignored", logq.size(), 0);
    send_ack(2'd0, 16'h0b00);
    tick(8);
    chk(logq.size() == 3 && logq[0] == rec(3'd3, 2'd0, 16'h0b00, 16'h3000, 16'h3001),
        "R4 fresh counter used", logq.size() > 0 ? logq[0] : 0,
        rec(3'd3, 2'd0, 16'h0b00, 16'h3000, 16'h3001));

    // R5: scheduled, buffer empty
    clear_q();
    lcnt = 16'h0aaa;
    send_msg(1'b1, 2'd2, 16'h5555, 16'h0040, 16'h0080);
    tick(4);
    chk(logq.size() == 1 && logq[0] == rec(3'd2, 2'd2, 16'h5555, 16'h0040, 16'h0080),
        "R5 received record", logq.size() > 0 ? logq[0] : 0,
        rec(3'd2, 2'd2, 16'h5555, 16'h0040, 16'h0080));
    chk(ackq.size() == 1 && ackq[0] == {2'd2, 16'h0aaa}, "R5 ack with local counter",
        ackq.size() > 0 ? ackq[0] : 0, {2'd2, 16'h0aaa});

    // R6: pending entries block
    clear_q();
    pend_empty = 0;
    send_msg(1'b0, 2'd0, 16'h6666, 16'h0100, 16'h0101);
    tick(5);
    chk(logq.size() == 0 && ackq.size() == 0, "R6 held while draining",
        logq.size() + ackq.size(), 0);
    chk(drain_req == 1, "R6 drain requested", drain_req, 1);
    pend_empty = 1;
    tick(4);
    chk(logq.size() == 1 && ackq.size() == 1 && drain_req == 0, "R6 proceeds after drain",
        {logq.size(), ackq.size()}, {32'd1, 32'd1});

    // R7: descheduled
    clear_q();
    sched = 0; lcnt = 16'h0777;
    send_msg(1'b0, 2'd3, 16'h7003, 16'h0200, 16'h0210);
    send_msg(1'b1, 2'd0, 16'h7000, 16'h0300, 16'h0310);
    tick(4);
    chk(ackq.size() == 2 && ackq[0] == {2'd3, 16'h0777} && ackq[1] == {2'd0, 16'h0777},
        "R7 immediate acks", ackq.size(), 2);
    chk(logq.size() == 0, "R7 not logged while descheduled", logq.size(), 0);
    lcnt = 16'h0888; sched = 1;
    tick(5);
    chk(logq.size() == 2 && logq[0] == rec(3'd1, 2'd3, 16'h7003, 16'h0200, 16'h0210)
        && logq[1] == rec(3'd2, 2'd0, 16'h7000, 16'h0300, 16'h0310),
        "R7 arrival order after reschedule", logq.size(), 2);
    chk(ackq.size() == 2, "R7 no second ack", ackq.size(), 2);

    // R8: own source ignored
    clear_q();
    send_msg(1'b0, 2'd1, 16'h8888, 16'h0, 16'h1);
    tick(4);
    chk(logq.size() == 0 && ackq.size() == 0, "R8 self message ignored",
        logq.size() + ackq.size(), 0);

    // R9: collision on the log port
    clear_q();
    lcnt = 16'h0999;
    start_call(1'b1, 16'h4000, 16'h4100);
    send_ack(2'd0, 16'h0900);
    send_ack(2'd2, 16'h0902);
    ack_in_v = 1; ack_in_src = 2'd3; ack_in_cnt = 16'h0903;
    rx_valid = 1; rx_kind = 0; rx_src = 2'd2; rx_cnt = 16'h9a9a; rx_lo = 16'h11; rx_hi = 16'h22;
    tick(1);
    ack_in_v = 0;
    rx_kind = 1; rx_src = 2'd0; rx_cnt = 16'h9b9b; rx_lo = 16'h33; rx_hi = 16'h44;
    tick(1);
    rx_valid = 0;
    tick(10);
    chk(logq.size() == 5, "R9 no record lost", logq.size(), 5);
    if (logq.size() == 5) begin
      chk(logq[1] == rec(3'd2, 2'd0, 16'h9b9b, 16'h33, 16'h44), "R9 received record wins",
          logq[1], rec(3'd2, 2'd0, 16'h9b9b, 16'h33, 16'h44));
      chk(logq[2] == rec(3'd4, 2'd0, 16'h0900, 16'h4000, 16'h4100), "R9 ack record delayed",
          logq[2], rec(3'd4, 2'd0, 16'h0900, 16'h4000, 16'h4100));
      chk(logq[4] == rec(3'd4, 2'd3, 16'h0903, 16'h4000, 16'h4100), "R9 last ack record",
          logq[4], rec(3'd4, 2'd3, 16'h0903, 16'h4000, 16'h4100));
    end

    // R5/R7/R10: random received traffic
    clear_q();
    lcnt = 16'h0c0c;
    for (int i = 0; i < 4; i++) per_src[i] = 0;
    for (int blk = 0; blk < 10; blk++) begin
      for (int j = 0; j < 6; j++) begin
        logic [1:0]  s;
        logic        k;
        logic [15:0] c, lo, hi;
        int unsigned r;
        r  = $urandom;
        s  = (r % 3 == 0) ? 2'd0 : (r % 3 == 1) ? 2'd2 : 2'd3;
        k  = r[8];
        c  = 16'($urandom); lo = 16'($urandom); hi = 16'($urandom);
        sched      = ($urandom % 3) != 0;
        pend_empty = ($urandom % 4) != 0;
        exp_log.push_back(rec(k ? 3'd2 : 3'd1, s, c, lo, hi));
        per_src[s]++;
        send_msg(k, s, c, lo, hi);
      end
      sched = 1; pend_empty = 1;
      tick(10);
    end
    tick(5);
    chk(logq.size() == exp_log.size(), "R7 random record count", logq.size(), exp_log.size());
    for (int i = 0; i < exp_log.size(); i++)
      if (i < logq.size())
        chk(logq[i] == exp_log[i], "R5 random record order", logq[i], exp_log[i]);
    for (int i = 0; i < 4; i++) got_src[i] = 0;
    foreach (ackq[i]) begin
      got_src[ackq[i][17:16]]++;
      chk(ackq[i][15:0] == 16'h0c0c, "R5 random ack counter", ackq[i][15:0], 16'h0c0c);
    end
    for (int i = 0; i < 4; i++)
      chk(got_src[i] == per_src[i], "R7 one ack per message", got_src[i], per_src[i]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule